// File: doc/BRIEF.md
# Multiplexed GPIO Port Pin Controller

This block manages an 8-bit bidirectional general-purpose port. Two bus-visible registers set its behaviour. A data register holds the value each pin drives. A direction register picks, for each bit, whether the pin is an output or an input. On a read of the data location, each bit returns its stored value when that bit is an output, and the synchronised pin level when it is an input.

The top pin is shared with other on-chip functions. In the address-expanded operating modes it carries an external address bit. In the other modes, the timer's I/O control field and its PWM bit decide whether the timer output owns the pin. When the timer does not own the pin, it works as a port pin. If its pulse-enable bit is set, it drives the pulse-pattern output instead of the data bit. The synchronised level of the top pin is also sent to the timer as a capture input when the timer field asks for one.

A hardware-standby input clears both registers and releases every pin to high impedance. A software-standby input freezes the registers, so their contents are kept.

Top module: `gpio_mux_port`

## Requirements
- R1: A bus write with `reg_wr`=1, `reg_sel`=0 and neither standby input asserted loads `reg_wdata` into the data register at the next rising clock edge. With `reg_sel`=1 it loads the direction register instead. A read with `reg_sel`=1 returns the direction register.
- R2: A read with `reg_sel`=0 returns, for each bit, the data register bit when the matching direction bit is 1, and the synchronised pin level when it is 0.
- R3: After reset, both registers are 0x00, so every pin is an input and `pin_oe` is 0x00.
- R4: While `hw_stby`=1, `pin_oe` is 0x00 in the same cycle. Both registers are cleared at the next edge, and bus writes are ignored.
- R5: While `sw_stby`=1 (and `hw_stby`=0), both registers keep their contents, bus writes are ignored, and the pins keep being driven as before.
- R6: When `mode` is 3, 4 or 6, pin 7 is an output carrying `addr_bit`, whatever the timer, pulse and direction settings are.
- R7: In any other mode, pin 7 is an output carrying `tmr_out` when `tmr_io` is 001, 010 or 011, or when `tmr_pwm`=1. This holds regardless of the direction and pulse-enable bits.
- R8: Otherwise pin 7 behaves as a port pin. With direction bit 7 = 0 it is an input. With direction bit 7 = 1 and `pls_en`=0 it drives data bit 7. With direction bit 7 = 1 and `pls_en`=1 it drives `pls_out`.
- R9: `tmr_cap_in` equals the synchronised level of pin 7 when `tmr_io[2]`=1, `tmr_pwm`=0 and the mode is not 3, 4 or 6. Otherwise it is 0.
- R10: Pins 6 to 0 have `pin_oe` equal to the direction bit and `pin_out` equal to the data bit.
- R11: A change on `pin_in` first appears on reads and on `tmr_cap_in` after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby: clear registers, float pins |
| sw_stby | input | 1 | Software standby: hold registers |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 data, 1 direction |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| mode | input | 3 | Operating mode number |
| tmr_io | input | 3 | Timer I/O control field for pin 7 |
| tmr_pwm | input | 1 | Timer PWM mode bit |
| tmr_out | input | 1 | Timer output value |
| tmr_cap_in | output | 1 | Capture input to timer |
| pls_en | input | 1 | Pulse-pattern enable for pin 7 |
| pls_out | input | 1 | Pulse-pattern output value |
| addr_bit | input | 1 | External address bit for pin 7 |
| pin_in | input | 8 | Pin input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
The assertions assume that `mode`, `tmr_io`, `tmr_pwm` and `pls_en` are quasi-static. They also assume that `pin_in` may be asynchronous, so they place no demand on the pin path beyond the capture gating. The stimulus changes the control inputs only on falling edges, samples the combinational pin arbitration one nanosecond later, and holds `pin_in` constant for at least three edges before it reads the data register or the capture input. Standby inputs are raised and lowered away from bus writes, except in the cases that test that a write is ignored.

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic [2:0]       mode,
  input  logic [2:0]       tmr_io,
  input  logic             tmr_pwm,
  input  logic             tmr_out,
  output logic             tmr_cap_in,
  input  logic             pls_en,
  input  logic             pls_out,
  input  logic             addr_bit,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] data_q, dir_q, pin_sync;
  logic [WIDTH-1:0] sync_q [SYNC_STAGES];
  logic addr_mode, cmp_sel, tmr_own, wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end
  assign pin_sync = sync_q[SYNC_STAGES-1];

  assign wr_ok = reg_wr && !hw_stby && !sw_stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (hw_stby) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (wr_ok) begin
      if (reg_sel) dir_q <= reg_wdata;
      else         data_q <= reg_wdata;
    end
  end

  assign reg_rdata = reg_sel ? dir_q : ((dir_q & data_q) | (~dir_q & pin_sync));

  assign addr_mode = (mode == 3'd3) || (mode == 3'd4) || (mode == 3'd6);
  assign cmp_sel   = !tmr_io[2] && (tmr_io[1:0] != 2'b00);
  assign tmr_own   = !addr_mode && (cmp_sel || tmr_pwm);

  always_comb begin
    pin_oe  = dir_q;
    pin_out = data_q;
    if (addr_mode) begin
      pin_oe[TOP]  = 1'b1;
      pin_out[TOP] = addr_bit;
    end else if (tmr_own) begin
      pin_oe[TOP]  = 1'b1;
      pin_out[TOP] = tmr_out;
    end else if (dir_q[TOP] && pls_en) begin
      pin_out[TOP] = pls_out;
    end
    if (hw_stby) pin_oe = '0;
  end

  assign tmr_cap_in = !addr_mode && tmr_io[2] && !tmr_pwm && pin_sync[TOP];

  a_r1_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && !hw_stby && !sw_stby) |=> data_q == $past(reg_wdata));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (data_q == '0 && dir_q == '0));

  a_r4_float: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> pin_oe == '0);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> ($stable(data_q) && $stable(dir_q)));

  a_r6_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mode && !hw_stby) |-> (pin_oe[TOP] && pin_out[TOP] == addr_bit));

  a_r7_timer: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_mode && tmr_pwm && !hw_stby) |-> (pin_oe[TOP] && pin_out[TOP] == tmr_out));

  a_r9_cap_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_io[2] || tmr_pwm || addr_mode) |-> !tmr_cap_in);

  a_r10_low: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_stby |-> (pin_oe[TOP-1:0] == dir_q[TOP-1:0] && pin_out[TOP-1:0] == data_q[TOP-1:0]));
endmodule

// File: tb/gpio_mux_port_tb.sv
module gpio_mux_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_stby = 1'b0, sw_stby = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [2:0] mode = 3'd1, tmr_io = 3'd0;
  logic tmr_pwm = 1'b0, tmr_out = 1'b0, tmr_cap_in;
  logic pls_en = 1'b0, pls_out = 1'b0, addr_bit = 1'b0;
  logic [7:0] pin_in = '0, pin_oe, pin_out;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_mux_port dut_i (.*);

  // fields: [12:10] mode, [9:7] tmr_io, [6] pwm, [5] dir7, [4] pls_en, [3:1] src, [0] cap
  // src: 0 input, 1 data, 2 timer, 3 pulse, 4 address
  localparam logic [12:0] VEC [14] = '{
    {3'd1, 3'b000, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0},
    {3'd1, 3'b000, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0},
    {3'd1, 3'b000, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0},
    {3'd2, 3'b001, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0},
    {3'd5, 3'b010, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0},
    {3'd7, 3'b011, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0},
    {3'd1, 3'b100, 1'b0, 1'b1, 1'b0, 3'd1, 1'b1},
    {3'd2, 3'b111, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1},
    {3'd5, 3'b110, 1'b0, 1'b1, 1'b1, 3'd3, 1'b1},
    {3'd7, 3'b100, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0},
    {3'd1, 3'b000, 1'b1, 1'b1, 1'b1, 3'd2, 1'b0},
    {3'd3, 3'b001, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0},
    {3'd4, 3'b100, 1'b0, 1'b1, 1'b1, 3'd4, 1'b0},
    {3'd6, 3'b000, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0}
  };

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic sel);
    reg_sel = sel;
    #1;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    pin_in = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R3 reset state
    chk("R3 pin_oe", pin_oe, 8'h00);
    rd(1'b1); chk("R3 dir", reg_rdata, 8'h00);
    wr(1'b1, 8'hFF);
    rd(1'b0); chk("R3 data", reg_rdata, 8'h00);

    // R1 write and read back
    wr(1'b0, 8'h5A);
    rd(1'b0); chk("R1 data", reg_rdata, 8'h5A);
    wr(1'b1, 8'h0F);
    rd(1'b1); chk("R1 dir", reg_rdata, 8'h0F);

    // R2 per-bit mux
    wr(1'b0, 8'h3C);
    rd(1'b0); chk("R2 mixed", reg_rdata, 8'hAC);
    wr(1'b1, 8'h00);
    rd(1'b0); chk("R2 all input", reg_rdata, 8'hA5);

    // R10 low pins
    wr(1'b1, 8'h53);
    chk("R10 oe", {1'b0, pin_oe[6:0]}, 8'h53);
    chk("R10 out", {1'b0, pin_out[6:0]}, {1'b0, 7'h3C});

    // R11 two-edge latency
    wr(1'b1, 8'h00);
    pin_in = 8'h3B;
    @(negedge clk); rd(1'b0); chk("R11 one edge", reg_rdata, 8'hA5);
    @(negedge clk); rd(1'b0); chk("R11 two edges", reg_rdata, 8'h3B);
    pin_in = 8'h80;
    repeat (3) @(negedge clk);

    // R6..R9 arbitration table
    foreach (VEC[k]) begin
      logic [12:0] v;
      v = VEC[k];
      mode = v[12:10]; tmr_io = v[9:7]; tmr_pwm = v[6]; pls_en = v[4];
      wr(1'b1, {v[5], 7'h00});
      for (int hot = 0; hot < 4; hot++) begin
        string rq;
        logic e;
        wr(1'b0, {hot == 3, 7'h00});
        addr_bit = (hot == 0); tmr_out = (hot == 1); pls_out = (hot == 2);
        #1;
        rq = (v[3:1] == 3'd4) ? "R6" : (v[3:1] == 3'd2) ? "R7" : "R8";
        chk({rq, " oe7"}, {7'h0, pin_oe[7]}, {7'h0, v[3:1] != 3'd0});
        case (v[3:1])
          3'd1: e = (hot == 3);
          3'd2: e = (hot == 1);
          3'd3: e = (hot == 2);
          3'd4: e = (hot == 0);
          default: e = pin_out[7];
        endcase
        chk({rq, " out7"}, {7'h0, pin_out[7]}, {7'h0, e});
        chk("R9 cap", {7'h0, tmr_cap_in}, {7'h0, v[0]});
      end
    end
    mode = 3'd1; tmr_io = 3'd0; tmr_pwm = 1'b0; pls_en = 1'b0;

    // R5 software standby
    wr(1'b1, 8'hF0);
    wr(1'b0, 8'h99);
    sw_stby = 1'b1;
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h0F);
    chk("R5 oe held", pin_oe, 8'hF0);
    chk("R5 out held", pin_out, 8'h99);
    sw_stby = 1'b0;
    rd(1'b1); chk("R5 dir kept", reg_rdata, 8'hF0);
    rd(1'b0); chk("R5 data kept", reg_rdata, 8'h90);

    // R4 hardware standby
    @(negedge clk);
    hw_stby = 1'b1; #1;
    chk("R4 float", pin_oe, 8'h00);
    wr(1'b0, 8'h77);
    hw_stby = 1'b0; #1;
    rd(1'b1); chk("R4 dir cleared", reg_rdata, 8'h00);
    wr(1'b1, 8'hFF);
    rd(1'b0); chk("R4 data cleared", reg_rdata, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule